// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Block

This block gathers 32 level-sensitive interrupt sources behind a 32-bit register bus and presents them to a processor on two request lines. One is the normal interrupt line and the other is the fast interrupt line. Software picks the line for each source through a routing mask. Each source has an enable bit and a software-trigger bit. Each of these is changed through a pair of registers: a write of one to the set register turns bits on, and a write of one to the clear register turns them off. Status registers show the raw, the normal-routed and the fast-routed view of the sources.

For the normal line the block also resolves priority in hardware. Sixteen vector slots each hold a handler address and a control word that names one source. A read of the current-vector register returns the handler address of the best slot that may fire, or the default address when no slot may fire. The read also acknowledges that slot. An acknowledged slot holds back itself and every slot of lower priority until software writes the current-vector register to end service. Four read-only words at the top of the map give an identification value, one byte per word.

Top module: `intc_vector_top`

## Requirements
- R1: After reset the enable, software-trigger, routing and slot-control state are all zero. Both request lines are low. The current-vector, default-vector and slot-address registers read zero.
- R2: Writing the enable register (0x10) sets the enable bits where the write data has ones. Writing 0x14 clears them in the same way. Zero bits leave the state alone. Reading 0x10 returns the enables. Reading 0x14 returns zero.
- R3: Writing 0x18 sets software-trigger bits and writing 0x1C clears them, with ones doing the work in both cases. Reading 0x18 returns the bits and reading 0x1C returns zero. The raw status at 0x08 is the source inputs ORed with these bits.
- R4: In the routing mask at 0x0C, a 1 sends a source to the fast line and a 0 sends it to the normal line. The normal status at 0x00 is raw AND enable AND NOT routing. The fast status at 0x04 is raw AND enable AND routing.
- R5: The normal request output is high when any normal status bit is set. The fast request output is high when any fast status bit is set.
- R6: Slot k has its address at 0x100+4k and its control at 0x200+4k. In the control word, bit 5 enables the slot and bits 4:0 name the source. A read of 0x30 returns the address of the lowest-numbered enabled, unmasked slot whose source is set in the normal status. A source routed to the fast line never selects a slot.
- R7: When no slot qualifies, a read of 0x30 returns the default address held at 0x34. That read changes no state.
- R8: A read of 0x30 that selects slot k marks k in service. While k is in service, slot k and every higher-numbered slot are masked. Lower-numbered slots can still be selected and nest.
- R9: A write to 0x30, with any data, ends service of the lowest-numbered slot in service, so masked slots become selectable again.
- R10: The words at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0 to 3 of the identification value in bits 7:0, so the vendor code sits in bits 19:12 of the assembled value. Writes to these addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Byte address of the register access |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle; data appears on the next cycle |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, registered |
| srcIn | input | 32 | Level-sensitive interrupt sources |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: 32 sources, 16 slots and the default identification value. With these values a slot's 5-bit source field can name every input. The 16-bit in-service vector is also wide enough to nest a high-priority slot (slot 1) over a low-priority one (slot 4). The bench leaves a disabled slot and a fast-routed source beside the enabled slots, so the default-address path and the masking path are each reached by one specific read.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_STAT_IRQ = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_STAT_FIQ = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_STAT_RAW = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_ROUTE    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_EN_SET   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR   = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_SW_SET   = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_SW_CLR   = 12'h01C;
  localparam logic [ADDR_W-1:0] OFF_GUARD    = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_CUR_VEC  = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_DEF_VEC  = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_TESTCTL  = 12'h300;

  typedef enum logic [3:0] {
    RD_ZERO, RD_IRQ, RD_FIQ, RD_RAW, RD_ROUTE, RD_EN, RD_SW,
    RD_GUARD, RD_CURVEC, RD_DEFVEC, RD_SLOTADDR, RD_SLOTCTL,
    RD_TEST, RD_ID
  } rd_sel_e;

  typedef struct packed {
    logic enSet;
    logic enClr;
    logic swSet;
    logic swClr;
    logic routeWr;
    logic guardWr;
    logic testWr;
    logic defWr;
    logic slotAddrWr;
    logic slotCtlWr;
    logic vecAck;
    logic vecEos;
  } strobe_t;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           strobe,
  output rd_sel_e           rdSel,
  output logic [SLOT_W-1:0] slotIdx,
  output logic [1:0]        idIdx
);

  logic inSlotAddr;
  logic inSlotCtl;
  logic inId;
  logic wordAligned;
  logic slotHighZero;

  assign wordAligned  = (addr[1:0] == 2'b00);
  assign slotHighZero = (addr[7:SLOT_W+2] == '0);
  assign inSlotAddr   = wordAligned && slotHighZero && (addr[11:8] == 4'h1);
  assign inSlotCtl    = wordAligned && slotHighZero && (addr[11:8] == 4'h2);
  assign inId         = wordAligned && (addr[11:4] == 8'hFE);
  assign slotIdx      = addr[SLOT_W+1:2];
  assign idIdx        = addr[3:2];

  always_comb begin
    strobe = '0;
    strobe.enSet      = wrEn && (addr == OFF_EN_SET);
    strobe.enClr      = wrEn && (addr == OFF_EN_CLR);
    strobe.swSet      = wrEn && (addr == OFF_SW_SET);
    strobe.swClr      = wrEn && (addr == OFF_SW_CLR);
    strobe.routeWr    = wrEn && (addr == OFF_ROUTE);
    strobe.guardWr    = wrEn && (addr == OFF_GUARD);
    strobe.testWr     = wrEn && (addr == OFF_TESTCTL);
    strobe.defWr      = wrEn && (addr == OFF_DEF_VEC);
    strobe.slotAddrWr = wrEn && inSlotAddr;
    strobe.slotCtlWr  = wrEn && inSlotCtl;
    strobe.vecEos     = wrEn && (addr == OFF_CUR_VEC);
    strobe.vecAck     = rdEn && (addr == OFF_CUR_VEC);
  end

  always_comb begin
    rdSel = RD_ZERO;
    if (inSlotAddr)     rdSel = RD_SLOTADDR;
    else if (inSlotCtl) rdSel = RD_SLOTCTL;
    else if (inId)      rdSel = RD_ID;
    else begin
      case (addr)
        OFF_STAT_IRQ: rdSel = RD_IRQ;
        OFF_STAT_FIQ: rdSel = RD_FIQ;
        OFF_STAT_RAW: rdSel = RD_RAW;
        OFF_ROUTE:    rdSel = RD_ROUTE;
        OFF_EN_SET:   rdSel = RD_EN;
        OFF_SW_SET:   rdSel = RD_SW;
        OFF_GUARD:    rdSel = RD_GUARD;
        OFF_CUR_VEC:  rdSel = RD_CURVEC;
        OFF_DEF_VEC:  rdSel = RD_DEFVEC;
        OFF_TESTCTL:  rdSel = RD_TEST;
        default:      rdSel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int          NUM_SRC  = 32,
  parameter int          NUM_SLOT = 16,
  parameter logic [31:0] ID_VALUE = 32'h0008_A5C3,
  localparam int         SRC_W    = $clog2(NUM_SRC),
  localparam int         SLOT_W   = $clog2(NUM_SLOT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  rd_sel_e             rdSel,
  input  logic [SLOT_W-1:0]   slotIdx,
  input  logic [1:0]          idIdx,
  input  logic                rdEn,
  input  logic [31:0]         wrData,
  input  logic [NUM_SRC-1:0]  srcIn,
  output logic [31:0]         rdData,
  output logic                irqOut,
  output logic                fiqOut,
  output logic [NUM_SRC-1:0]  enState,
  output logic [NUM_SRC-1:0]  swState,
  output logic [NUM_SLOT-1:0] inSvc,
  output logic                vecHit
);

  logic [NUM_SRC-1:0]  routeReg;
  logic                guardReg;
  logic                testReg;
  logic [31:0]         defVec;
  logic [31:0]         slotAddr [NUM_SLOT];
  logic                slotEn   [NUM_SLOT];
  logic [SRC_W-1:0]    slotSrc  [NUM_SLOT];
  logic [NUM_SRC-1:0]  rawStat;
  logic [NUM_SRC-1:0]  irqStat;
  logic [NUM_SRC-1:0]  fiqStat;
  logic [NUM_SLOT-1:0] slotCand;
  logic [NUM_SLOT-1:0] maskChain;
  logic [SLOT_W-1:0]   vecIdx;
  logic [NUM_SRC-1:0]  wrSrc;
  logic [31:0]         rdMux;

  assign wrSrc   = wrData[NUM_SRC-1:0];
  assign rawStat = srcIn | swState;
  assign irqStat = rawStat & enState & ~routeReg;
  assign fiqStat = rawStat & enState & routeReg;
  assign irqOut  = |irqStat;
  assign fiqOut  = |fiqStat;

  function automatic logic [31:0] widen(input logic [NUM_SRC-1:0] v);
    logic [31:0] t;
    t = '0;
    t[NUM_SRC-1:0] = v;
    return t;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enState  <= '0;
      swState  <= '0;
      routeReg <= '0;
      guardReg <= 1'b0;
      testReg  <= 1'b0;
      defVec   <= '0;
    end else begin
      if (strobe.enSet)   enState  <= enState | wrSrc;
      if (strobe.enClr)   enState  <= enState & ~wrSrc;
      if (strobe.swSet)   swState  <= swState | wrSrc;
      if (strobe.swClr)   swState  <= swState & ~wrSrc;
      if (strobe.routeWr) routeReg <= wrSrc;
      if (strobe.guardWr) guardReg <= wrData[0];
      if (strobe.testWr)  testReg  <= wrData[0];
      if (strobe.defWr)   defVec   <= wrData;
    end
  end

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotAddr[g] <= '0;
        slotEn[g]   <= 1'b0;
        slotSrc[g]  <= '0;
      end else begin
        if (strobe.slotAddrWr && (slotIdx == SLOT_W'(g))) slotAddr[g] <= wrData;
        if (strobe.slotCtlWr && (slotIdx == SLOT_W'(g))) begin
          slotEn[g]  <= wrData[SRC_W];
          slotSrc[g] <= wrData[SRC_W-1:0];
        end
      end
    end
    if (g == 0) begin : g_head
      assign maskChain[g] = inSvc[g];
    end else begin : g_tail
      assign maskChain[g] = maskChain[g-1] | inSvc[g];
    end
    assign slotCand[g] = slotEn[g] && irqStat[slotSrc[g]] && !maskChain[g];
  end

  always_comb begin
    vecHit = 1'b0;
    vecIdx = '0;
    for (int i = NUM_SLOT - 1; i >= 0; i--) begin
      if (slotCand[i]) begin
        vecHit = 1'b1;
        vecIdx = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSvc <= '0;
    end else if (strobe.vecEos) begin
      inSvc <= inSvc & (inSvc - 1'b1);
    end else if (strobe.vecAck && vecHit) begin
      inSvc[vecIdx] <= 1'b1;
    end
  end

  always_comb begin
    rdMux = '0;
    case (rdSel)
      RD_IRQ:      rdMux = widen(irqStat);
      RD_FIQ:      rdMux = widen(fiqStat);
      RD_RAW:      rdMux = widen(rawStat);
      RD_ROUTE:    rdMux = widen(routeReg);
      RD_EN:       rdMux = widen(enState);
      RD_SW:       rdMux = widen(swState);
      RD_GUARD:    rdMux[0] = guardReg;
      RD_TEST:     rdMux[0] = testReg;
      RD_CURVEC:   rdMux = vecHit ? slotAddr[vecIdx] : defVec;
      RD_DEFVEC:   rdMux = defVec;
      RD_SLOTADDR: rdMux = slotAddr[slotIdx];
      RD_SLOTCTL: begin
        rdMux[SRC_W]     = slotEn[slotIdx];
        rdMux[SRC_W-1:0] = slotSrc[slotIdx];
      end
      RD_ID:       rdMux[7:0] = ID_VALUE[idIdx*8 +: 8];
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdMux;
  end

endmodule

// File: rtl/intc_vector_top.sv
module intc_vector_top
  import intc_pkg::*;
#(
  parameter int          NUM_SRC  = 32,
  parameter int          NUM_SLOT = 16,
  parameter logic [31:0] ID_VALUE = 32'h0008_A5C3,
  localparam int         SLOT_W   = $clog2(NUM_SLOT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               fiqOut
);

  strobe_t             strobe;
  rd_sel_e             rdSel;
  logic [SLOT_W-1:0]   slotIdx;
  logic [1:0]          idIdx;
  logic [NUM_SRC-1:0]  enState;
  logic [NUM_SRC-1:0]  swState;
  logic [NUM_SLOT-1:0] inSvc;
  logic                vecHit;

  intc_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
    .addr    (addr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .slotIdx (slotIdx),
    .idIdx   (idIdx)
  );

  intc_datapath #(
    .NUM_SRC  (NUM_SRC),
    .NUM_SLOT (NUM_SLOT),
    .ID_VALUE (ID_VALUE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .slotIdx (slotIdx),
    .idIdx   (idIdx),
    .rdEn    (rdEn),
    .wrData  (wrData),
    .srcIn   (srcIn),
    .rdData  (rdData),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut),
    .enState (enState),
    .swState (swState),
    .inSvc   (inSvc),
    .vecHit  (vecHit)
  );

endmodule

// File: rtl/intc_vector_chk.sv
module intc_vector_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   addr,
  input logic                wrEn,
  input logic                rdEn,
  input logic [31:0]         wrData,
  input logic [NUM_SRC-1:0]  enState,
  input logic [NUM_SRC-1:0]  swState,
  input logic [NUM_SLOT-1:0] inSvc,
  input logic                vecHit
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rstN |=> (enState == '0 && swState == '0 && inSvc == '0));

  // R2
  en_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_EN_CLR) |=> ((enState & $past(wrData[NUM_SRC-1:0])) == '0));

  // R3
  sw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_SW_SET)
      |=> ((swState & $past(wrData[NUM_SRC-1:0])) == $past(wrData[NUM_SRC-1:0])));

  // R8
  ack_marks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == OFF_CUR_VEC && vecHit) |=> (inSvc != '0));

  // R9
  eos_pops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_CUR_VEC && inSvc != '0)
      |=> ($countones(inSvc) + 1 == $countones($past(inSvc))));

endmodule

bind intc_vector_top intc_vector_chk #(
  .NUM_SRC  (NUM_SRC),
  .NUM_SLOT (NUM_SLOT)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .addr    (addr),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .wrData  (wrData),
  .enState (enState),
  .swState (swState),
  .inSvc   (inSvc),
  .vecHit  (vecHit)
);

// File: tb/sim_intc_vector_top.sv
`timescale 1ns/1ps
module sim_intc_vector_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] srcIn = '0;
  logic        irqOut;
  logic        fiqOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  intc_vector_top u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .srcIn(srcIn),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdExp(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic chkOut(input logic eIrq, input logic eFiq, input string tag);
    @(negedge clk);
    checks++;
    if (irqOut !== eIrq || fiqOut !== eFiq) begin
      errors++;
      $display("FAIL %s irq/fiq actual %b%b expected %b%b", tag, irqOut, fiqOut, eIrq, eFiq);
    end
  endtask

  // monitor: pop expected item for each read captured at a rising edge
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn) begin
        @(negedge clk);
        if (expQ.size() > 0) begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          checks++;
          if (rdData !== e) begin
            errors++;
            $display("FAIL %s actual %h expected %h", t, rdData, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkOut(1'b0, 1'b0, "R1 outputs");
    rdExp(12'h010, 32'h0, "R1 enable");
    rdExp(12'h018, 32'h0, "R1 soft");
    rdExp(12'h00C, 32'h0, "R1 route");
    rdExp(12'h200, 32'h0, "R1 slot ctrl");
    rdExp(12'h100, 32'h0, "R1 slot addr");
    rdExp(12'h030, 32'h0, "R1 current vector");
    rdExp(12'h034, 32'h0, "R1 default vector");

    // R2 enable set/clear
    wr(12'h010, 32'h0000_00F0);
    wr(12'h010, 32'h0000_000F);
    rdExp(12'h010, 32'h0000_00FF, "R2 set accumulates");
    wr(12'h014, 32'h0000_003C);
    rdExp(12'h010, 32'h0000_00C3, "R2 clear");
    rdExp(12'h014, 32'h0, "R2 clear reads zero");

    // R3 software triggers and raw status
    srcIn = 32'h0000_0100;
    wr(12'h018, 32'h0001_0001);
    rdExp(12'h018, 32'h0001_0001, "R3 soft set");
    rdExp(12'h008, 32'h0001_0101, "R3 raw status");
    wr(12'h01C, 32'h0000_0001);
    rdExp(12'h018, 32'h0001_0000, "R3 soft clear");
    rdExp(12'h01C, 32'h0, "R3 clear reads zero");

    // R4 R5 routing and request lines
    wr(12'h010, 32'h0001_0100);
    rdExp(12'h000, 32'h0001_0100, "R4 irq status all normal");
    chkOut(1'b1, 1'b0, "R5 normal only");
    wr(12'h00C, 32'h0000_0100);
    rdExp(12'h000, 32'h0001_0000, "R4 irq status");
    rdExp(12'h004, 32'h0000_0100, "R4 fiq status");
    chkOut(1'b1, 1'b1, "R5 both lines");
    wr(12'h014, 32'h0001_0000);
    chkOut(1'b0, 1'b1, "R5 fast only");
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h01C, 32'hFFFF_FFFF);
    wr(12'h00C, 32'h0);
    srcIn = 32'h0;
    chkOut(1'b0, 1'b0, "R5 quiet");

    // vector setup
    for (int k = 0; k < 16; k++) wr(12'(12'h100 + 4 * k), 32'hA000_0000 + 32'(k * 16));
    wr(12'h204, 32'h0000_0023);
    wr(12'h210, 32'h0000_0027);
    wr(12'h208, 32'h0000_0009);
    wr(12'h034, 32'hDEF0_0000);
    wr(12'h010, 32'h0000_0288);
    rdExp(12'h210, 32'h0000_0027, "R6 slot ctrl readback");

    // R7 disabled slot source only -> default
    srcIn = 32'h0000_0200;
    rdExp(12'h030, 32'hDEF0_0000, "R7 default vector");
    // R6 slot 4 selected
    srcIn = 32'h0000_0280;
    rdExp(12'h030, 32'hA000_0040, "R6 slot4 vector");
    // R8 slot 4 now masked
    rdExp(12'h030, 32'hDEF0_0000, "R8 self masked");
    // R8 higher priority nests
    srcIn = 32'h0000_0288;
    rdExp(12'h030, 32'hA000_0010, "R8 nested slot1");
    rdExp(12'h030, 32'hDEF0_0000, "R8 all masked");
    // R9 end of service frees slot1
    wr(12'h030, 32'h0);
    rdExp(12'h030, 32'hA000_0010, "R9 slot1 again");
    wr(12'h030, 32'h0);
    wr(12'h030, 32'h0);
    srcIn = 32'h0000_0080;
    rdExp(12'h030, 32'hA000_0040, "R9 slot4 after release");
    wr(12'h030, 32'h0);
    // R6 fast-routed source never selects a slot
    wr(12'h00C, 32'h0000_0080);
    rdExp(12'h030, 32'hDEF0_0000, "R6 fast source ignored");
    chkOut(1'b0, 1'b1, "R6 fast line");

    // R10 identification words
    rdExp(12'hFE0, 32'h0000_00C3, "R10 id0");
    rdExp(12'hFE4, 32'h0000_00A5, "R10 id1");
    rdExp(12'hFE8, 32'h0000_0008, "R10 id2");
    rdExp(12'hFEC, 32'h0000_0000, "R10 id3");
    wr(12'hFE4, 32'hFFFF_FFFF);
    rdExp(12'hFE4, 32'h0000_00A5, "R10 write ignored");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard left %0d items expected 0", expQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule